// File: doc/BRIEF.md
# Masked Packed Left Shifter

This block is a SIMD execution slice that shifts every element of a packed vector towards the most significant end by one common bit count. The low-order bits that the shift vacates are filled with zeros, and no bit ever crosses into a neighbouring element. Elements may be 16, 32 or 64 bits wide, and the active vector may be 128, 256 or 512 bits long. The count comes either from a 64-bit register operand or from an 8-bit immediate. If the count is larger than the element width minus one, every shifted element becomes zero.

After the shift, a per-lane writemask selects which lanes take the new value. A lane whose mask bit is clear either keeps the old destination lane or is forced to zero. Masking can be switched off altogether. In the immediate form, element zero of the source can be broadcast to every lane. Destination bits above the active length are either kept (legacy policy) or cleared.

The result is registered. A valid strobe follows the input strobe by one clock, and the output holds its value between operations.

Top module: `packed_shl_unit`

## Requirements
- R1: Each element of `elem_sz` width (0 = 16 bits, 1 = 32 bits, 2 or 3 = 64 bits) is shifted left by the count, independently of the others. The vacated low bits become zero, and no bit moves across an element boundary.
- R2: The count is compared as a full 64-bit unsigned value. When it is greater than or equal to the element width, every shifted element is zero, including counts that have only bits 63..8 set.
- R3: With `use_imm` = 1, the count is `imm_cnt` zero-extended to 64 bits and `reg_cnt` has no effect. With `use_imm` = 0, `reg_cnt` is used, and it carries the low 64 bits of any wider count operand.
- R4: `vec_len` selects the active length (0 = 128, 1 = 256, 2 or 3 = 512 bits). The active length divided by the element width gives the number of lanes, and lane n uses `wmask[n]`. Mask bits at or above the lane count have no effect.
- R5: With `mask_en` = 1 and `zero_fill` = 0, a lane whose mask bit is 0 takes the old destination lane from `dst_old`.
- R6: With `mask_en` = 1 and `zero_fill` = 1, a lane whose mask bit is 0 is written as zero.
- R7: With `mask_en` = 0, every lane inside the active length takes the shifted value, whatever `wmask` holds.
- R8: Output bits above the active length take `dst_old` when `keep_upper` = 1 and are zero when `keep_upper` = 0.
- R9: With `use_imm` = 1, `bcast` = 1 and 32- or 64-bit elements, source element 0 is replicated into every lane before the shift. For 16-bit elements, or when `use_imm` = 0, `bcast` has no effect.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_vec` changes only after a cycle with `in_valid` high and otherwise holds its value.
- R11: While reset is held, `out_valid` is 0 and `out_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | VW | Source vector |
| dst_old | input | VW | Old destination vector |
| reg_cnt | input | 64 | Register count (low 64 bits of the count operand) |
| imm_cnt | input | 8 | Immediate count |
| use_imm | input | 1 | Select the immediate count |
| elem_sz | input | 2 | Element width select |
| vec_len | input | 2 | Active vector length select |
| wmask | input | VW/16 | Per-lane writemask, lane 0 in bit 0 |
| mask_en | input | 1 | Enable the writemask |
| zero_fill | input | 1 | Masked-off lanes become zero instead of old values |
| bcast | input | 1 | Broadcast element 0 (immediate form only) |
| keep_upper | input | 1 | Keep old destination bits above the active length |
| out_valid | output | 1 | Result strobe |
| out_vec | output | VW | New destination vector |

## Verification
Saturation and merge masking can act on the same operation. An out-of-range count zeroes the enabled lanes, while the masked-off lanes must still show the old destination. The sweep provokes this by pairing every boundary count (width minus one, width, 255, upper-only bits) with random masks in merge mode, zero mode and with masking disabled, for each element width and length. Each result is judged against an arithmetic lane-by-lane model in the bench, which also checks that the bits above the active length follow the selected policy.

// File: rtl/shl_pkg.sv
package shl_pkg;
    localparam logic [1:0] ES_16  = 2'd0;
    localparam logic [1:0] ES_32  = 2'd1;
    localparam logic [1:0] VL_128 = 2'd0;
    localparam logic [1:0] VL_256 = 2'd1;
    localparam int         CNT_W  = 64;
    localparam int         GRAN_W = 16;
endpackage

// File: rtl/shl_count_sel.sv
module shl_count_sel
    import shl_pkg::*;
(
    input  logic [CNT_W-1:0] reg_cnt,
    input  logic [7:0]       imm_cnt,
    input  logic             use_imm,
    input  logic [1:0]       elem_sz,
    output logic [5:0]       amt,
    output logic             sat
);
    logic [CNT_W-1:0] cnt_full;

    always_comb begin
        cnt_full = use_imm ? {{(CNT_W-8){1'b0}}, imm_cnt} : reg_cnt;
        amt      = cnt_full[5:0];
        // any bit at or above the element width saturates the result
        sat      = (|cnt_full[CNT_W-1:6])
                 | ((elem_sz == ES_16) & (|cnt_full[5:4]))
                 | ((elem_sz == ES_32) & cnt_full[5]);
    end
endmodule

// File: rtl/shl_elem_shift.sv
module shl_elem_shift
    import shl_pkg::*;
#(
    parameter int VW = 512
) (
    input  logic [VW-1:0] src_vec,
    input  logic          bcast_en,
    input  logic [1:0]    elem_sz,
    input  logic [5:0]    amt,
    input  logic          sat,
    output logic [VW-1:0] shifted
);
    localparam int NQ = VW / 64;

    logic [VW-1:0] src_b;

    always_comb begin
        if (bcast_en && elem_sz == ES_32)
            src_b = {(VW/32){src_vec[31:0]}};
        else if (bcast_en && elem_sz != ES_16)
            src_b = {NQ{src_vec[63:0]}};
        else
            src_b = src_vec;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_quad
        logic [63:0] chunk, s16, s32, s64;
        assign chunk = src_b[q*64 +: 64];
        for (genvar h = 0; h < 4; h++) begin : g_half16
            assign s16[h*16 +: 16] = chunk[h*16 +: 16] << amt[3:0];
        end
        for (genvar k = 0; k < 2; k++) begin : g_half32
            assign s32[k*32 +: 32] = chunk[k*32 +: 32] << amt[4:0];
        end
        assign s64 = chunk << amt;
        assign shifted[q*64 +: 64] = sat ? 64'd0 :
                                     (elem_sz == ES_16) ? s16 :
                                     (elem_sz == ES_32) ? s32 : s64;
    end
endmodule

// File: rtl/shl_lane_merge.sv
module shl_lane_merge
    import shl_pkg::*;
#(
    parameter int VW = 512
) (
    input  logic [VW-1:0]        shifted,
    input  logic [VW-1:0]        dst_old,
    input  logic [VW/GRAN_W-1:0] wmask,
    input  logic                 mask_en,
    input  logic                 zero_fill,
    input  logic                 keep_upper,
    input  logic [1:0]           elem_sz,
    input  logic [1:0]           vec_len,
    output logic [VW-1:0]        result
);
    localparam int NG = VW / GRAN_W;

    logic [NG-1:0] lane_on;
    logic [NG-1:0] in_len;

    for (genvar g = 0; g < NG; g++) begin : g_gran
        logic mbit;
        assign mbit = (elem_sz == ES_16) ? wmask[g] :
                      (elem_sz == ES_32) ? wmask[g/2] : wmask[g/4];
        assign lane_on[g] = ~mask_en | mbit;
        assign in_len[g]  = (g < 8)
                          | ((g < 16) & (vec_len != VL_128))
                          | ((g < 32) & (vec_len != VL_128) & (vec_len != VL_256));
        assign result[g*GRAN_W +: GRAN_W] =
            in_len[g]  ? (lane_on[g] ? shifted[g*GRAN_W +: GRAN_W]
                                     : (zero_fill ? '0 : dst_old[g*GRAN_W +: GRAN_W]))
                       : (keep_upper ? dst_old[g*GRAN_W +: GRAN_W] : '0);
    end
endmodule

// File: rtl/packed_shl_unit.sv
module packed_shl_unit
    import shl_pkg::*;
#(
    parameter int VW = 512
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VW-1:0]        src_vec,
    input  logic [VW-1:0]        dst_old,
    input  logic [CNT_W-1:0]     reg_cnt,
    input  logic [7:0]           imm_cnt,
    input  logic                 use_imm,
    input  logic [1:0]           elem_sz,
    input  logic [1:0]           vec_len,
    input  logic [VW/GRAN_W-1:0] wmask,
    input  logic                 mask_en,
    input  logic                 zero_fill,
    input  logic                 bcast,
    input  logic                 keep_upper,
    output logic                 out_valid,
    output logic [VW-1:0]        out_vec
);
    typedef struct packed {
        logic          vld;
        logic [VW-1:0] data;
    } pipe_t;

    pipe_t         st_d, st_q;
    logic [5:0]    amt;
    logic          sat;
    logic [VW-1:0] shifted;
    logic [VW-1:0] merged;

    shl_count_sel u_cnt (
        .reg_cnt (reg_cnt),
        .imm_cnt (imm_cnt),
        .use_imm (use_imm),
        .elem_sz (elem_sz),
        .amt     (amt),
        .sat     (sat)
    );

    shl_elem_shift #(.VW(VW)) u_shift (
        .src_vec  (src_vec),
        .bcast_en (bcast & use_imm),
        .elem_sz  (elem_sz),
        .amt      (amt),
        .sat      (sat),
        .shifted  (shifted)
    );

    shl_lane_merge #(.VW(VW)) u_merge (
        .shifted    (shifted),
        .dst_old    (dst_old),
        .wmask      (wmask),
        .mask_en    (mask_en),
        .zero_fill  (zero_fill),
        .keep_upper (keep_upper),
        .elem_sz    (elem_sz),
        .vec_len    (vec_len),
        .result     (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid)
            st_d.data = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_vec   = st_q.data;
endmodule

// File: rtl/shl_checker.sv
module shl_checker #(
    parameter int VW = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VW-1:0]    src_vec,
    input logic [VW-1:0]    dst_old,
    input logic [63:0]      reg_cnt,
    input logic             use_imm,
    input logic [1:0]       vec_len,
    input logic [VW/16-1:0] wmask,
    input logic             mask_en,
    input logic             zero_fill,
    input logic             keep_upper,
    input logic             out_valid,
    input logic [VW-1:0]    out_vec
);
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));

    assert_sat_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !use_imm && (|reg_cnt[63:6]) && !mask_en && vec_len == 2'd2)
        |=> out_vec == '0);

    assert_zero_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && zero_fill && wmask == '0 && !keep_upper)
        |=> out_vec == '0);

    assert_merge_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_en && !zero_fill && wmask == '0 && keep_upper)
        |=> out_vec == $past(dst_old));

    assert_nomask_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mask_en && !use_imm && reg_cnt == 64'd0 && vec_len == 2'd2)
        |=> out_vec == $past(src_vec));

    assert_upper_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && keep_upper && vec_len == 2'd0)
        |=> out_vec[VW-1:128] == $past(dst_old[VW-1:128]));

    assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !keep_upper && vec_len == 2'd0)
        |=> out_vec[VW-1:128] == '0);
endmodule

bind packed_shl_unit shl_checker #(.VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .src_vec    (src_vec),
    .dst_old    (dst_old),
    .reg_cnt    (reg_cnt),
    .use_imm    (use_imm),
    .vec_len    (vec_len),
    .wmask      (wmask),
    .mask_en    (mask_en),
    .zero_fill  (zero_fill),
    .keep_upper (keep_upper),
    .out_valid  (out_valid),
    .out_vec    (out_vec)
);

// File: tb/packed_shl_unit_bench.sv
`timescale 1ns/1ps
module packed_shl_unit_bench;
    localparam int VW = 512;
    localparam int NL = VW / 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_vec = '0;
    logic [VW-1:0] dst_old = '0;
    logic [63:0]   reg_cnt = '0;
    logic [7:0]    imm_cnt = '0;
    logic          use_imm = 1'b0;
    logic [1:0]    elem_sz = '0;
    logic [1:0]    vec_len = '0;
    logic [NL-1:0] wmask = '0;
    logic          mask_en = 1'b0;
    logic          zero_fill = 1'b0;
    logic          bcast = 1'b0;
    logic          keep_upper = 1'b0;
    logic          out_valid;
    logic [VW-1:0] out_vec;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    packed_shl_unit #(.VW(VW)) u_packed_shl_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
        .dst_old(dst_old), .reg_cnt(reg_cnt), .imm_cnt(imm_cnt), .use_imm(use_imm),
        .elem_sz(elem_sz), .vec_len(vec_len), .wmask(wmask), .mask_en(mask_en),
        .zero_fill(zero_fill), .bcast(bcast), .keep_upper(keep_upper),
        .out_valid(out_valid), .out_vec(out_vec)
    );

    function automatic logic [VW-1:0] rand_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // lane-by-lane arithmetic model built from the requirements
    function automatic logic [VW-1:0] model();
        int w, vb, nl, c, idx;
        logic [63:0] cnt;
        logic [63:0] e, sh;
        logic [VW-1:0] r;
        logic on;
        w   = 16 << ((elem_sz > 2'd2) ? 2 : int'(elem_sz));
        vb  = 128 << ((vec_len > 2'd2) ? 2 : int'(vec_len));
        nl  = vb / w;
        cnt = use_imm ? {56'd0, imm_cnt} : reg_cnt;
        r   = keep_upper ? dst_old : '0;
        for (int l = 0; l < nl; l++) begin
            e = '0;
            sh = '0;
            for (int b = 0; b < w; b++) begin
                idx = (bcast && use_imm && w != 16) ? b : l*w + b;
                e[b] = src_vec[idx];
            end
            if (cnt < 64'(w)) begin
                c = int'(cnt);
                for (int b = 0; b < w; b++)
                    if (b >= c) sh[b] = e[b-c];
            end
            on = !mask_en || wmask[l];
            for (int b = 0; b < w; b++)
                r[l*w + b] = on ? sh[b] : (zero_fill ? 1'b0 : dst_old[l*w + b]);
        end
        return r;
    endfunction

    task automatic check_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // inputs set at a falling edge; result registered at the next rising edge
    // and sampled at the falling edge after it
    task automatic run_op(string tag, output logic [VW-1:0] exp);
        exp = model();
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R10 valid one cycle later", out_valid, 1'b1);
        check_vec(tag, out_vec, exp);
    endtask

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [VW-1:0] exp;
        logic [VW-1:0] last;
        logic [63:0] w64;
        string tag;
        last = '0;

        // R11: reset state
        repeat (3) @(negedge clk);
        check_bit("R11 reset valid", out_valid, 1'b0);
        check_vec("R11 reset data", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int esz = 0; esz < 3; esz++) begin
            for (int vl = 0; vl < 3; vl++) begin
                for (int mode = 0; mode < 5; mode++) begin
                    for (int ci = 0; ci < 10; ci++) begin
                        w64 = 64'(16 << esz);
                        elem_sz    = 2'(esz);
                        vec_len    = 2'(vl);
                        src_vec    = rand_vec();
                        dst_old    = rand_vec();
                        wmask      = NL'({$urandom, $urandom});
                        mask_en    = (mode != 0);
                        zero_fill  = (mode == 2) || (mode == 4);
                        keep_upper = (mode == 3);
                        bcast      = (mode == 4) ? 1'b1 : 1'($urandom);
                        reg_cnt    = {$urandom, $urandom};
                        imm_cnt    = 8'($urandom);
                        use_imm    = 1'b0;
                        case (ci)
                            0: reg_cnt = 64'd0;
                            1: begin use_imm = 1'b1; imm_cnt = 8'd1; end
                            2: reg_cnt = w64 - 64'd1;
                            3: reg_cnt = w64;
                            4: begin use_imm = 1'b1; imm_cnt = 8'd255; end
                            5: reg_cnt = 64'd1 << 40;
                            6: reg_cnt = 64'h8000_0000_0000_0003;
                            7: begin use_imm = 1'b1; imm_cnt = 8'(w64 - 64'd1); end
                            8: reg_cnt = 64'($urandom_range(0, 16*(1<<esz) - 1));
                            default: begin
                                use_imm = 1'b1;
                                imm_cnt = 8'($urandom_range(0, 16*(1<<esz) - 1));
                            end
                        endcase
                        if (mode == 3)                         tag = "R8 upper bits";
                        else if (ci == 9)                      tag = "R3 imm count, reg count ignored";
                        else if (mode == 4)                    tag = "R9 broadcast";
                        else if (ci >= 3 && ci <= 6)           tag = "R2 count saturation";
                        else if (mode == 1 && vl != 2)         tag = "R4 lane count";
                        else if (mode == 1)                    tag = "R5 merge";
                        else if (mode == 2)                    tag = "R6 zero lanes";
                        else if (ci <= 2)                      tag = "R1 element shift";
                        else                                   tag = "R7 mask disabled";
                        run_op(tag, exp);
                        last = exp;
                    end
                end
            end
        end

        // R10: output holds while inputs change without a strobe
        for (int i = 0; i < 3; i++) begin
            src_vec = rand_vec();
            dst_old = rand_vec();
            reg_cnt = 64'd1;
            @(negedge clk);
            check_bit("R10 idle valid", out_valid, 1'b0);
            check_vec("R10 hold", out_vec, last);
        end

        // R1: fixed pattern, 16-bit lanes, shift by 4, no crossing
        src_vec = {NL{16'hF00F}};
        dst_old = '0; mask_en = 1'b0; keep_upper = 1'b0; use_imm = 1'b0;
        reg_cnt = 64'd4; elem_sz = 2'd0; vec_len = 2'd2; bcast = 1'b0;
        run_op("R1 fixed pattern", exp);
        check_vec("R1 fixed pattern arith", out_vec, {NL{16'h00F0}});

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule